// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block rules on four system instructions in a core that may carry a hypervisor extension. The instructions are wait-for-interrupt, the supervisor address-translation fence, and the two hypervisor fences (guest virtual and guest physical). For each request it decides among three outcomes: the instruction executes, it raises an illegal-instruction exception, or it raises a virtual-instruction exception. When an instruction executes, wait-for-interrupt becomes a halt request and a fence becomes a TLB flush request. The decision depends on the current privilege level, the virtualization mode, the trap-on-wait (TW) and trap-on-translation (TVM) status bits, the hypervisor's virtual trap-on-translation bit (VTVM), and whether the hypervisor extension is present.

A request is a single-cycle `req_valid` strobe together with a one-hot class vector. The block has no back-pressure. It takes one request per clock, and each result appears as a one-cycle pulse on the clock edge after the request. The TLB and the interrupt wake-up logic sit outside the block. They consume `flush_req` and `halt_req`. The trap pipeline consumes `trap_valid` and `trap_cause`.

Top module: `priv_trap_checker`

## Requirements
- R1: While reset is active, and on the first cycle after it, `halt_req`, `flush_req` and `trap_valid` are low and `trap_cause` is 0.
- R2: A request is accepted when `req_valid` is high and `req_class` has exactly one bit set. Bit 0 is wait-for-interrupt, bit 1 is the supervisor fence, bit 2 is the guest-virtual hypervisor fence and bit 3 is the guest-physical hypervisor fence. The result is visible for exactly one cycle, on the edge after acceptance. A cycle with no accepted request (valid low, or zero or several class bits set) produces no output.
- R3: Each accepted request raises exactly one of `halt_req`, `flush_req` or `trap_valid`. `trap_cause` is 2 for an illegal-instruction trap and 22 for a virtual-instruction trap, and it is 0 whenever `trap_valid` is low.
- R4: Privilege is encoded as user=0, supervisor=1 and machine=3. Wait-for-interrupt traps with cause 22 when virtualization is on, or when the privilege is supervisor and TW is set. In every other case it raises `halt_req`.
- R5: The supervisor fence traps with cause 2 at user privilege, and at supervisor privilege when TVM is set.
- R6: A supervisor fence that passes R5 traps with cause 22 when the hypervisor is present, virtualization is on and VTVM is set. Otherwise it raises `flush_req`.
- R7: The guest-virtual hypervisor fence traps with cause 22 at supervisor privilege with virtualization on. It raises `flush_req` at machine privilege, or at supervisor privilege with virtualization off. At user privilege it traps with cause 2.
- R8: The guest-physical hypervisor fence traps with cause 2 at supervisor privilege when virtualization is off and TVM is set. Otherwise it follows R7.
- R9: The outcome of wait-for-interrupt does not depend on TVM, VTVM or hypervisor presence. No fence outcome depends on TW. Wait-for-interrupt never flushes, and no fence ever halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_class | input | 4 | One-hot instruction class (bit 0 wait, bit 1 supervisor fence, bit 2 guest-virtual fence, bit 3 guest-physical fence) |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_on | input | 1 | Virtualization mode active |
| st_tw | input | 1 | Status: trap wait-for-interrupt in supervisor |
| st_tvm | input | 1 | Status: trap translation management in supervisor |
| hs_vtvm | input | 1 | Hypervisor status: trap translation management in virtual supervisor |
| hyp_present | input | 1 | Hypervisor extension implemented |
| halt_req | output | 1 | Halt pulse for an executed wait-for-interrupt |
| flush_req | output | 1 | TLB flush pulse for an executed fence |
| trap_valid | output | 1 | Exception pulse |
| trap_cause | output | CAUSE_W (5) | Exception cause code, valid with `trap_valid` |

## Verification
The hardest outcome to reach from the ports is the virtual-instruction trap on the supervisor fence. It needs five inputs lined up at once: supervisor privilege, TVM clear, hypervisor present, virtualization on and VTVM set. Clearing any one of them gives a flush or an illegal trap instead. The stimulus therefore sweeps every class against every legal privilege and all 32 combinations of the five mode bits, so this corner and its neighbours are each driven. The sweep is interleaved with idle and malformed-class cycles, which confirm that results never leak into the following cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  localparam int NUM_CLASS = 4;
  localparam int PRIV_W    = 2;

  localparam int CLS_WAIT   = 0;
  localparam int CLS_SFENCE = 1;
  localparam int CLS_HVVMA  = 2;
  localparam int CLS_HGVMA  = 3;

  localparam logic [PRIV_W-1:0] PRIV_USER    = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUPER   = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'd3;

  localparam int CODE_ILLEGAL = 2;
  localparam int CODE_VIRTUAL = 22;

  typedef enum logic [1:0] {
    VERDICT_RUN     = 2'd0,
    VERDICT_ILLEGAL = 2'd1,
    VERDICT_VIRTUAL = 2'd2
  } verdict_e;

endpackage

// File: rtl/ptc_wait_rule.sv
module ptc_wait_rule
  import ptc_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt,
  input  logic              tw,
  output verdict_e          verdict
);

  logic super_trap;

  // TW only applies to supervisor; any virtualized wait is a virtual trap
  assign super_trap = (priv == PRIV_SUPER) && tw;

  always_comb begin
    if (super_trap || virt) verdict = VERDICT_VIRTUAL;
    else                    verdict = VERDICT_RUN;
  end

endmodule

// File: rtl/ptc_sfence_rule.sv
module ptc_sfence_rule
  import ptc_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt,
  input  logic              tvm,
  input  logic              vtvm,
  input  logic              hyp,
  output verdict_e          verdict
);

  logic below_super;
  logic tvm_block;
  logic guest_block;

  assign below_super = (priv < PRIV_SUPER);
  assign tvm_block   = (priv == PRIV_SUPER) && tvm;
  assign guest_block = hyp && virt && vtvm;

  // Illegal check takes precedence over the virtual check
  always_comb begin
    if (below_super || tvm_block) verdict = VERDICT_ILLEGAL;
    else if (guest_block)         verdict = VERDICT_VIRTUAL;
    else                          verdict = VERDICT_RUN;
  end

endmodule

// File: rtl/ptc_hfence_rule.sv
module ptc_hfence_rule
  import ptc_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt,
  input  logic              tvm_gate,  // tied low for the guest-virtual variant
  output verdict_e          verdict
);

  logic is_super;
  logic pre_block;
  logic allowed;

  assign is_super  = (priv == PRIV_SUPER);
  assign pre_block = is_super && !virt && tvm_gate;
  assign allowed   = (priv == PRIV_MACHINE) || (is_super && !virt);

  always_comb begin
    if (pre_block)             verdict = VERDICT_ILLEGAL;
    else if (is_super && virt) verdict = VERDICT_VIRTUAL;
    else if (allowed)          verdict = VERDICT_RUN;
    else                       verdict = VERDICT_ILLEGAL;
  end

endmodule

// File: rtl/priv_trap_checker.sv
module priv_trap_checker
  import ptc_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [NUM_CLASS-1:0] req_class,
  input  logic [PRIV_W-1:0]    cur_priv,
  input  logic                 virt_on,
  input  logic                 st_tw,
  input  logic                 st_tvm,
  input  logic                 hs_vtvm,
  input  logic                 hyp_present,
  output logic                 halt_req,
  output logic                 flush_req,
  output logic                 trap_valid,
  output logic [CAUSE_W-1:0]   trap_cause
);

  localparam logic [CAUSE_W-1:0] CAUSE_ILL  = CAUSE_W'(CODE_ILLEGAL);
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT = CAUSE_W'(CODE_VIRTUAL);

  verdict_e verdict [NUM_CLASS];
  verdict_e sel;
  logic     accept;

  ptc_wait_rule u_wait (
    .priv    (cur_priv),
    .virt    (virt_on),
    .tw      (st_tw),
    .verdict (verdict[CLS_WAIT])
  );

  ptc_sfence_rule u_sfence (
    .priv    (cur_priv),
    .virt    (virt_on),
    .tvm     (st_tvm),
    .vtvm    (hs_vtvm),
    .hyp     (hyp_present),
    .verdict (verdict[CLS_SFENCE])
  );

  // Both hypervisor fences share one rule; the guest-physical one adds the TVM gate
  for (genvar g = CLS_HVVMA; g <= CLS_HGVMA; g++) begin : g_hfence
    ptc_hfence_rule u_rule (
      .priv     (cur_priv),
      .virt     (virt_on),
      .tvm_gate ((g == CLS_HGVMA) ? st_tvm : 1'b0),
      .verdict  (verdict[g])
    );
  end

  assign accept = req_valid && $onehot(req_class);

  always_comb begin
    sel = VERDICT_RUN;
    for (int i = 0; i < NUM_CLASS; i++) begin
      if (req_class[i]) sel = verdict[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req   <= 1'b0;
      flush_req  <= 1'b0;
      trap_valid <= 1'b0;
      trap_cause <= '0;
    end else begin
      halt_req   <= accept && (sel == VERDICT_RUN) && req_class[CLS_WAIT];
      flush_req  <= accept && (sel == VERDICT_RUN) && !req_class[CLS_WAIT];
      trap_valid <= accept && (sel != VERDICT_RUN);
      if (accept && sel == VERDICT_ILLEGAL)      trap_cause <= CAUSE_ILL;
      else if (accept && sel == VERDICT_VIRTUAL) trap_cause <= CAUSE_VIRT;
      else                                       trap_cause <= '0;
    end
  end

  // ---------------- assertions ----------------
  assert_single_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({halt_req, flush_req, trap_valid}) <= 1);

  assert_cause_values_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_cause == CAUSE_ILL || trap_cause == CAUSE_VIRT));

  assert_cause_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> (trap_cause == '0));

  assert_no_request_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && $onehot(req_class)) |=> !(halt_req || flush_req || trap_valid));

  assert_request_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $onehot(req_class)) |=> (halt_req || flush_req || trap_valid));

  assert_wait_virtual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 4'b0001 && virt_on) |=> (trap_valid && trap_cause == CAUSE_VIRT));

  assert_sfence_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 4'b0010 && cur_priv == PRIV_USER) |=> (trap_valid && trap_cause == CAUSE_ILL));

  assert_sfence_guest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 4'b0010 && cur_priv == PRIV_SUPER && !st_tvm &&
     hyp_present && virt_on && hs_vtvm) |=> (trap_valid && trap_cause == CAUSE_VIRT));

  assert_hvvma_machine_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 4'b0100 && cur_priv == PRIV_MACHINE) |=> flush_req);

  assert_hgvma_tvm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 4'b1000 && cur_priv == PRIV_SUPER && !virt_on && st_tvm)
    |=> (trap_valid && trap_cause == CAUSE_ILL));

  assert_wait_never_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 4'b0001) |=> !flush_req);

  assert_fence_never_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_class[CLS_WAIT]) |=> !halt_req);

endmodule

// File: tb/priv_trap_checker_tb.sv
module priv_trap_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic       h;
    logic       f;
    logic       t;
    logic [4:0] c;
    bit         is_req;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_class = '0;
  logic [1:0] cur_priv = '0;
  logic       virt_on = 1'b0, st_tw = 1'b0, st_tvm = 1'b0, hs_vtvm = 1'b0, hyp_present = 1'b0;
  logic       halt_req, flush_req, trap_valid;
  logic [4:0] trap_cause;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_trap_checker u_dut (
    .clk, .rst_n, .req_valid, .req_class, .cur_priv, .virt_on, .st_tw,
    .st_tvm, .hs_vtvm, .hyp_present, .halt_req, .flush_req, .trap_valid, .trap_cause
  );

  function automatic exp_t model(int cls, logic [1:0] p, logic v, logic tw,
                                 logic tvm, logic vt, logic hy);
    exp_t e;
    int   kind;  // 0 run, 1 illegal, 2 virtual
    e.h = 0; e.f = 0; e.t = 0; e.c = 0; e.is_req = 1;
    case (cls)
      0: kind = ((p == 1 && tw) || v) ? 2 : 0;                        // R4
      1: begin                                                         // R5 R6
        if (p == 0 || (p == 1 && tvm)) kind = 1;
        else if (hy && v && vt)        kind = 2;
        else                           kind = 0;
      end
      default: begin                                                   // R7 R8
        if (cls == 3 && p == 1 && !v && tvm) kind = 1;
        else if (p == 1 && v)                kind = 2;
        else if (p == 3 || (p == 1 && !v))   kind = 0;
        else                                 kind = 1;
      end
    endcase
    if (kind == 0) begin
      if (cls == 0) e.h = 1; else e.f = 1;
    end else begin
      e.t = 1;
      e.c = (kind == 1) ? 5'd2 : 5'd22;
    end
    if (cls == 0)      e.tag = (tvm || vt) ? "R4,R9" : "R4";
    else if (cls == 1) e.tag = tw ? "R5,R6,R9" : "R5,R6";
    else if (cls == 2) e.tag = tw ? "R7,R9" : "R7";
    else               e.tag = tw ? "R8,R9" : "R8";
    return e;
  endfunction

  task automatic drive_req(int cls, logic [1:0] p, logic v, logic tw,
                           logic tvm, logic vt, logic hy);
    @(negedge clk);
    req_valid = 1; req_class = 4'b0001 << cls; cur_priv = p;
    virt_on = v; st_tw = tw; st_tvm = tvm; hs_vtvm = vt; hyp_present = hy;
    sb.push_back(model(cls, p, v, tw, tvm, vt, hy));
  endtask

  task automatic drive_none(logic vld, logic [3:0] cls);
    exp_t e;
    @(negedge clk);
    req_valid = vld; req_class = cls; cur_priv = 2'd3; virt_on = 0;
    e.h = 0; e.f = 0; e.t = 0; e.c = 0; e.is_req = 0; e.tag = "R2";
    sb.push_back(e);
  endtask

  // monitor: compare one result per cycle, just after the edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (halt_req !== e.h || flush_req !== e.f || trap_valid !== e.t || trap_cause !== e.c) begin
        failures++;
        $display("FAIL %s: got h=%0d f=%0d t=%0d c=%0d expected h=%0d f=%0d t=%0d c=%0d",
                 e.tag, halt_req, flush_req, trap_valid, trap_cause, e.h, e.f, e.t, e.c);
      end
      if (e.is_req) begin
        checks++;
        if ($countones({halt_req, flush_req, trap_valid}) != 1) begin
          failures++;
          $display("FAIL R3: got %0d outcomes expected 1",
                   $countones({halt_req, flush_req, trap_valid}));
        end
      end
    end
  end

  task automatic check_idle_r1(string when);
    checks++;
    if (halt_req !== 0 || flush_req !== 0 || trap_valid !== 0 || trap_cause !== 0) begin
      failures++;
      $display("FAIL R1 (%s): got h=%0d f=%0d t=%0d c=%0d expected all 0",
               when, halt_req, flush_req, trap_valid, trap_cause);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle_r1("in reset");
    rst_n = 1;
    @(negedge clk);
    check_idle_r1("after reset");

    // directed corner: supervisor fence guest trap and its neighbours (R6)
    drive_req(1, 2'd1, 1, 0, 0, 1, 1);
    drive_req(1, 2'd1, 1, 0, 0, 1, 0);
    drive_req(1, 2'd1, 1, 0, 1, 1, 1);
    drive_none(0, 4'b0000);

    // malformed or absent requests (R2)
    drive_none(1, 4'b0000);
    drive_none(1, 4'b0011);
    drive_none(1, 4'b1100);
    drive_none(0, 4'b0001);

    // full sweep
    for (int cls = 0; cls < 4; cls++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int m = 0; m < 32; m++) begin
          logic [1:0] p;
          p = (pi == 2) ? 2'd3 : 2'(pi);
          drive_req(cls, p, m[0], m[1], m[2], m[3], m[4]);
          if (m % 7 == 6) drive_none(0, 4'b1000);
        end
      end
    end
    drive_none(0, 4'b0000);

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule